// File: doc/BRIEF.md
# Snooping MESI Line Controller

This block is the coherence controller for one private cache on a shared snooping bus. It keeps a four-state coherence tag (Modified, Exclusive, Shared, Invalid) and an address tag for every entry of a small direct-mapped line array. Data storage, memory timing and arbitration between caches sit outside it. The block turns processor reads and writes into bus reads, read-exclusives and write-back flushes. It also watches the transactions that other caches put on the bus, answers them through a wired-OR shared output plus flush and cache-to-cache supply strobes, and updates its own line states to match.

A processor request is held on the request port until the controller pulses its done output. A request that needs the bus raises a bus request and keeps operation and address steady until the arbiter grants. In the grant cycle the bus carries the transaction, and for a read the wired-OR shared input is sampled then. Snoops arrive one per cycle on a separate port. The block answers them combinationally in the same cycle and updates state at the next clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_done` are low, and a snooped read to any address gets no shared, flush or supply response.
- R2: A processor read that misses issues one bus read (`bus_op` = 1) for the request address. The line becomes Exclusive when `bus_shared_in` is low in the grant cycle and Shared when it is high. `cpu_done` is high in the cycle after the grant.
- R3: A processor write that misses issues one read-exclusive (`bus_op` = 2) for the request address, and the line becomes Modified.
- R4: A write hit on an Exclusive line makes it Modified with no bus request. `cpu_done` is high in the cycle after the request is accepted.
- R5: A write hit on a Shared line issues one read-exclusive for the request address and then leaves the line Modified.
- R6: Read hits in Modified, Exclusive or Shared, and write hits in Modified, raise `cpu_done` in the cycle after acceptance, cause no bus request and leave the state unchanged.
- R7: A snooped read (`snp_op` = 1) that hits a valid line raises `snp_shared` in the same cycle. From Modified it also raises `snp_flush`; from Exclusive it raises `snp_supply`. Either way the line ends Shared. A Shared line stays Shared.
- R8: A snooped read-exclusive (`snp_op` = 2) that hits a valid line makes it Invalid, raises `snp_flush` when the line was Modified, and never raises `snp_shared`.
- R9: A miss whose indexed line is Modified under another tag first issues a write-back (`bus_op` = 3) to the victim address `{victim tag, index}` and then the fill. A clean victim is replaced with no write-back.
- R10: While `bus_req` is high and `bus_gnt` low, the request, `bus_op` and `bus_addr` stay unchanged. Each grant-wait cycle adds one cycle to the request latency.
- R11: A snoop that hits the line indexed by a pending processor request in the same cycle takes effect first, and the request is evaluated again a cycle later against the new state.
- R12: Snoops that miss (other tag or Invalid line), and snooped write-backs (`snp_op` = 3), produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present, held until `cpu_done` |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address; low bits index the line, the rest are the tag |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for the shared bus |
| bus_op | output | 2 | 1 read, 2 read-exclusive, 3 write-back, 0 none |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches, sampled at grant |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_op | input | 2 | Operation of the snooped transaction, same coding as `bus_op` |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_shared | output | 1 | This cache holds a copy (drives the wired-OR line) |
| snp_flush | output | 1 | This cache flushes its dirty copy |
| snp_supply | output | 1 | This cache supplies clean data cache-to-cache |

## Verification
Assertions watch, on every cycle, the request holding its operation and address until granted, a completion pulse after each grant, a fill following every write-back, the silent Exclusive-to-Modified completion, and the state a snooped hit leaves behind. Only the bench's sweeps can show that whole sequences are right. Those sequences are the exact order and addresses of write-back and fill, the choice of Exclusive or Shared from the shared input, the delay that a snoop collision adds, and the state left in each line. The bench reads that state back by probing each line with a snooped read.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_RDX  = 2'd2,
        OP_WB   = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        F_IDLE = 3'd0,
        F_WB   = 3'd1,
        F_FILL = 3'd2,
        F_UPG  = 3'd3,
        F_DONE = 3'd4
    } ctl_st_e;

    typedef struct packed {
        logic     hit;
        logic     shared;
        logic     flush;
        logic     supply;
        line_st_e nxt;
    } snp_resp_t;

    // Reaction of one line to a transaction observed from another cache.
    function automatic snp_resp_t snoop_react(line_st_e cur, bus_op_e op,
                                              logic valid, logic tag_eq);
        snp_resp_t r;
        r     = '0;
        r.nxt = cur;
        r.hit = valid && tag_eq && (cur != ST_I) &&
                (op == OP_RD || op == OP_RDX);
        if (r.hit) begin
            r.flush = (cur == ST_M);
            if (op == OP_RD) begin
                r.shared = 1'b1;
                r.supply = (cur == ST_E);
                r.nxt    = ST_S;
            end else begin
                r.nxt    = ST_I;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid,
    input  bus_op_e          snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_hit,
    output logic             snp_shared,
    output logic             snp_flush,
    output logic             snp_supply,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output line_st_e         rd_st,
    input  logic             lwr_en,
    input  logic [IDX_W-1:0] lwr_idx,
    input  logic [TAG_W-1:0] lwr_tag,
    input  line_st_e         lwr_st
);

    line_st_e [NUM_LINES-1:0]             st_v;
    logic     [NUM_LINES-1:0][TAG_W-1:0]  tag_v;
    snp_resp_t                            resp;

    always_comb begin
        resp = snoop_react(st_v[snp_idx], snp_op, snp_valid,
                           tag_v[snp_idx] == snp_tag);
    end

    assign snp_hit    = resp.hit;
    assign snp_shared = resp.shared;
    assign snp_flush  = resp.flush;
    assign snp_supply = resp.supply;
    assign rd_tag     = tag_v[rd_idx];
    assign rd_st      = st_v[rd_idx];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_st_e         st_r;
        logic [TAG_W-1:0] tag_r;
        logic             snp_here;
        logic             lwr_here;

        assign snp_here = resp.hit && (snp_idx == IDX_W'(g));
        assign lwr_here = lwr_en && (lwr_idx == IDX_W'(g));

        // A snoop to this line overrides any local update in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                st_r  <= ST_I;
                tag_r <= '0;
            end else if (snp_here) begin
                st_r  <= resp.nxt;
            end else if (lwr_here) begin
                st_r  <= lwr_st;
                tag_r <= lwr_tag;
            end
        end

        assign st_v[g]  = st_r;
        assign tag_v[g] = tag_r;
    end

    // R7
    snoop_rd_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (resp.hit && snp_op == OP_RD && st_v[snp_idx] == ST_M)
        |=> st_v[$past(snp_idx)] == ST_S);

    // R8
    snoop_rdx_inval_chk: assert property (@(posedge clk) disable iff (rst)
        (resp.hit && snp_op == OP_RDX) |=> st_v[$past(snp_idx)] == ST_I);

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              bus_req,
    output bus_op_e           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_hit,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  line_st_e          rd_st,
    output logic              lwr_en,
    output logic [IDX_W-1:0]  lwr_idx,
    output logic [TAG_W-1:0]  lwr_tag,
    output line_st_e          lwr_st
);

    ctl_st_e           state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic              latch;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              hit;
    logic              conflict;

    always_comb begin
        if (state_q == F_IDLE) begin
            cur_idx = cpu_addr[IDX_W-1:0];
            cur_tag = cpu_addr[ADDR_W-1:IDX_W];
        end else begin
            cur_idx = addr_q[IDX_W-1:0];
            cur_tag = addr_q[ADDR_W-1:IDX_W];
        end
    end

    assign rd_idx   = cur_idx;
    assign hit      = (rd_st != ST_I) && (rd_tag == cur_tag);
    assign conflict = snp_hit && (snp_idx == cur_idx);

    always_comb begin
        state_d  = state_q;
        latch    = 1'b0;
        cpu_done = 1'b0;
        bus_req  = 1'b0;
        bus_op   = OP_NONE;
        bus_addr = '0;
        lwr_en   = 1'b0;
        lwr_idx  = cur_idx;
        lwr_tag  = cur_tag;
        lwr_st   = ST_I;
        unique case (state_q)
            F_IDLE: begin
                if (cpu_valid && !conflict) begin
                    latch = 1'b1;
                    if (hit) begin
                        if (!cpu_we) begin
                            state_d = F_DONE;
                        end else begin
                            unique case (rd_st)
                                ST_M:    state_d = F_DONE;
                                ST_E: begin
                                    lwr_en  = 1'b1;
                                    lwr_st  = ST_M;
                                    state_d = F_DONE;
                                end
                                default: state_d = F_UPG;
                            endcase
                        end
                    end else if (rd_st == ST_M) begin
                        state_d = F_WB;
                    end else begin
                        state_d = F_FILL;
                    end
                end
            end
            F_WB: begin
                if (rd_st != ST_M) begin
                    // victim already cleaned by a snoop: nothing to write back
                    state_d = F_FILL;
                end else begin
                    bus_req  = 1'b1;
                    bus_op   = OP_WB;
                    bus_addr = {rd_tag, cur_idx};
                    if (bus_gnt) begin
                        lwr_en  = 1'b1;
                        lwr_tag = rd_tag;
                        lwr_st  = ST_I;
                        state_d = F_FILL;
                    end
                end
            end
            F_FILL: begin
                bus_req  = 1'b1;
                bus_op   = we_q ? OP_RDX : OP_RD;
                bus_addr = addr_q;
                if (bus_gnt) begin
                    lwr_en  = 1'b1;
                    lwr_st  = we_q ? ST_M : (bus_shared_in ? ST_S : ST_E);
                    state_d = F_DONE;
                end
            end
            F_UPG: begin
                bus_req  = 1'b1;
                bus_op   = OP_RDX;
                bus_addr = addr_q;
                if (bus_gnt) begin
                    lwr_en  = 1'b1;
                    lwr_st  = ST_M;
                    state_d = F_DONE;
                end
            end
            F_DONE: begin
                cpu_done = 1'b1;
                state_d  = F_IDLE;
            end
            default: state_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= F_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (latch) begin
                we_q   <= cpu_we;
                addr_q <= cpu_addr;
            end
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !snp_hit)
        |=> (bus_req && $stable(bus_op) && $stable(bus_addr)));

    // R2, R3
    grant_done_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && (bus_op == OP_RD || bus_op == OP_RDX))
        |=> cpu_done);

    // R9
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && bus_op == OP_WB)
        |=> (bus_req && (bus_op == OP_RD || bus_op == OP_RDX)));

    // R4
    silent_upgrade_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == F_IDLE && cpu_valid && cpu_we && !conflict && hit &&
         rd_st == ST_E) |=> (cpu_done && !bus_req));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LINES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic              snp_supply
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    bus_op_e          bus_op_w;
    bus_op_e          snp_op_w;
    logic             snp_hit;
    logic [IDX_W-1:0] rd_idx;
    logic [TAG_W-1:0] rd_tag;
    line_st_e         rd_st;
    logic             lwr_en;
    logic [IDX_W-1:0] lwr_idx;
    logic [TAG_W-1:0] lwr_tag;
    line_st_e         lwr_st;

    assign snp_op_w = bus_op_e'(snp_op);
    assign bus_op   = bus_op_w;

    mesi_line_array #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .snp_valid  (snp_valid),
        .snp_op     (snp_op_w),
        .snp_idx    (snp_addr[IDX_W-1:0]),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .snp_hit    (snp_hit),
        .snp_shared (snp_shared),
        .snp_flush  (snp_flush),
        .snp_supply (snp_supply),
        .rd_idx     (rd_idx),
        .rd_tag     (rd_tag),
        .rd_st      (rd_st),
        .lwr_en     (lwr_en),
        .lwr_idx    (lwr_idx),
        .lwr_tag    (lwr_tag),
        .lwr_st     (lwr_st)
    );

    mesi_req_fsm #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cpu_valid     (cpu_req_valid),
        .cpu_we        (cpu_req_we),
        .cpu_addr      (cpu_req_addr),
        .cpu_done      (cpu_done),
        .bus_req       (bus_req),
        .bus_op        (bus_op_w),
        .bus_addr      (bus_addr),
        .bus_gnt       (bus_gnt),
        .bus_shared_in (bus_shared_in),
        .snp_hit       (snp_hit),
        .snp_idx       (snp_addr[IDX_W-1:0]),
        .rd_idx        (rd_idx),
        .rd_tag        (rd_tag),
        .rd_st         (rd_st),
        .lwr_en        (lwr_en),
        .lwr_idx       (lwr_idx),
        .lwr_tag       (lwr_tag),
        .lwr_st        (lwr_st)
    );

endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req_valid = 1'b0;
    logic       cpu_req_we = 1'b0;
    logic [7:0] cpu_req_addr = '0;
    logic       cpu_done;
    logic       bus_req;
    logic [1:0] bus_op;
    logic [7:0] bus_addr;
    logic       bus_gnt = 1'b0;
    logic       bus_shared_in = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_op = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_shared, snp_flush, snp_supply;

    int checks = 0;
    int failures = 0;
    // model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
    int mst [4];
    int mtag[4];

    always #2.5 clk = ~clk;

    mesi_line_ctrl dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_supply(snp_supply)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_snoop(input logic [1:0] op, input logic [7:0] a, input string rq);
        int i, t, es, ef, ep;
        bit h;
        i = int'(a[1:0]);
        t = int'(a[7:2]);
        h = (mst[i] != 0) && (mtag[i] == t) && (op == 2'd1 || op == 2'd2);
        es = (h && op == 2'd1) ? 1 : 0;
        ef = (h && mst[i] == 3) ? 1 : 0;
        ep = (h && op == 2'd1 && mst[i] == 2) ? 1 : 0;
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        #1;
        chk(rq, "snoop shared", int'(snp_shared), es);
        chk(rq, "snoop flush", int'(snp_flush), ef);
        chk(rq, "snoop supply", int'(snp_supply), ep);
        @(negedge clk);
        snp_valid = 1'b0; snp_op = '0;
        if (h) mst[i] = (op == 2'd1) ? 1 : 0;
    endtask

    // Processor request with a behavioural bus: grant after d wait cycles.
    // pre: a snooped read to the same address arrives in the first cycle.
    task automatic do_cpu(input bit we, input logic [7:0] a, input bit shr,
                          input int d, input bit pre);
        int i, t, eops, ens, elat, n, lat, w;
        int eop[2];
        int ead[2];
        int gop[4];
        int gad[4];
        bit hit, bad_hold;
        logic [1:0] hop;
        logic [7:0] had;
        string rq;
        i = int'(a[1:0]);
        t = int'(a[7:2]);
        if (pre && mst[i] != 0 && mtag[i] == t) mst[i] = 1;
        hit = (mst[i] != 0) && (mtag[i] == t);
        eops = 0;
        if (hit) begin
            if (we && mst[i] == 1) begin
                eop[0] = 2; ead[0] = int'(a); eops = 1; rq = "R5";
            end else begin
                rq = (we && mst[i] == 2) ? "R4" : "R6";
            end
            ens = we ? 3 : mst[i];
        end else begin
            if (mst[i] == 3) begin
                eop[0] = 3; ead[0] = (mtag[i] << 2) | i; eops = 1;
            end
            eop[eops] = we ? 2 : 1; ead[eops] = int'(a); eops++;
            rq = (mst[i] == 3) ? "R9" : (we ? "R3" : "R2");
            ens = we ? 3 : (shr ? 1 : 2);
        end
        if (pre) rq = "R11";
        elat = 1 + (pre ? 1 : 0) + eops * (1 + d);

        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a;
        if (pre) begin
            snp_valid = 1'b1; snp_op = 2'd1; snp_addr = a;
            #1;
            chk("R11", "collision snoop shared", int'(snp_shared), 1);
        end
        n = 0; lat = 0; w = 0; bad_hold = 1'b0; hop = '0; had = '0;
        forever begin
            @(negedge clk);
            snp_valid = 1'b0; snp_op = '0;
            bus_gnt = 1'b0;
            lat++;
            if (cpu_done || lat > 100) break;
            if (bus_req) begin
                if (w == 0) begin hop = bus_op; had = bus_addr; end
                else if (bus_op != hop || bus_addr != had) bad_hold = 1'b1;
                if (w >= d) begin
                    bus_gnt = 1'b1; bus_shared_in = shr;
                    if (n < 4) begin gop[n] = int'(bus_op); gad[n] = int'(bus_addr); end
                    n++;
                    w = 0;
                end else begin
                    w++;
                end
            end
        end
        cpu_req_valid = 1'b0;
        chk(rq, "bus transactions", n, eops);
        for (int k = 0; k < eops && k < n; k++) begin
            chk(rq, "bus op", gop[k], eop[k]);
            chk(rq, "bus addr", gad[k], ead[k]);
        end
        chk("R10", "latency", lat, elat);
        chk("R10", "held request changed", int'(bad_hold), 0);
        mst[i] = ens;
        mtag[i] = t;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin mst[k] = 0; mtag[k] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "bus_req after reset", int'(bus_req), 0);
        chk("R1", "cpu_done after reset", int'(cpu_done), 0);
        for (int k = 0; k < 4; k++) do_snoop(2'd1, 8'(k), "R1");

        // Sweep: every line, every starting state, every action.
        for (int li = 0; li < 4; li++) begin
            for (int s = 0; s < 4; s++) begin
                for (int a = 0; a < 6; a++) begin
                    logic [7:0] ad;
                    int d;
                    ad = {6'(s * 8 + a + li * 3), 2'(li)};
                    d = (s + a + li) % 3;
                    do_snoop(2'd2, ad, "R8");
                    if (s == 1) do_cpu(1'b0, ad, 1'b1, d, 1'b0);
                    else if (s == 2) do_cpu(1'b0, ad, 1'b0, d, 1'b0);
                    else if (s == 3) do_cpu(1'b1, ad, 1'b0, d, 1'b0);
                    case (a)
                        0: do_cpu(1'b0, ad, li[0], d, 1'b0);
                        1: do_cpu(1'b1, ad, 1'b0, d, 1'b0);
                        2: do_snoop(2'd1, ad, "R7");
                        3: do_snoop(2'd2, ad, "R8");
                        4: do_snoop(2'd3, ad, "R12");
                        default: do_snoop(2'd1, ad ^ 8'h80, "R12");
                    endcase
                    // read back the line state through a snooped read
                    do_snoop(2'd1, ad, "R12");
                end
            end
        end

        // R11: snoop collides with a write to an Exclusive line
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ad;
            ad = {6'(40 + k), 2'(k)};
            do_snoop(2'd2, ad, "R8");
            do_cpu(1'b0, ad, 1'b0, k % 2, 1'b0);
            do_cpu(1'b1, ad, 1'b0, k % 2, 1'b1);
            do_snoop(2'd1, ad, "R11");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule